// File: doc/BRIEF.md
# Associative Translation Entry Array

This block is a small, fully associative store of address-translation entries. Each entry covers a pair of adjacent pages, one even and one odd. It holds a virtual page tag, a per-entry page mask, an 8-bit address-space identifier and a global flag. Each of the two halves carries its own frame number, a 3-bit cache attribute, a dirty bit and a valid bit.

Two independent combinational search ports are provided. The lookup port returns a hit flag, the matching slot number and the full contents of that slot as packed register words. The probe port returns only the slot number, or a not-found flag.

Software fills the array through an indexed write port. Slot numbers beyond the array are dropped. A flush command empties the whole array in one cycle. A next-slot pointer follows the most recent write, and a replacement engine outside the block may use it.

Top module: `assoc_xlate_array`

## Requirements
- R1: An entry's tag matches a searched page number when the two are equal in every bit position where that entry's page mask holds a 0. Positions where the mask holds a 1 are not compared.
- R2: A tag match also needs either the entry's global flag to be set or its stored identifier to equal the searched 8-bit identifier. The global flag is the AND of bit 0 of the even and odd write words.
- R3: An entry takes part in a search only if at least one of its two half valid bits (bit 1 of each half word) is set.
- R4: When several entries match, both ports report the lowest-numbered one.
- R5: The probe port gives `pr_miss`=0 and the matching slot on a match. When no entry matches, it gives `pr_miss`=1 and `pr_idx`=0. A lookup miss gives `lk_hit`=0 and all lookup data outputs 0.
- R6: A write whose slot number is ENTRIES or larger leaves every entry and the next-slot pointer unchanged.
- R7: Flush clears every field of every entry, including both valid bits, and sets the next-slot pointer to 0. Flush wins over a write in the same cycle.
- R8: Each half word has the frame number from bit 6 upward, the attribute in bits 5:3, dirty in bit 2, valid in bit 1 and global in bit 0. The tag word is the page number shifted left by 11, ORed with the identifier in bits 7:0, with bits 10:8 zero.
- R9: An accepted write takes effect at the clock edge. A search in the following cycle sees the new contents, and the next-slot pointer becomes (slot+1) modulo ENTRIES.
- R10: After reset the array is empty and the next-slot pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Clear all entries |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W+1 | Target slot (may exceed the array) |
| wr_pn | input | PN_W | Page number to store |
| wr_mask | input | PN_W | Page mask to store |
| wr_asid | input | 8 | Identifier to store |
| wr_even | input | PFN_W+6 | Even half word |
| wr_odd | input | PFN_W+6 | Odd half word |
| lk_pn | input | PN_W | Lookup page number |
| lk_asid | input | 8 | Lookup identifier |
| lk_hit | output | 1 | Lookup matched |
| lk_idx | output | IDX_W | Matching slot |
| lk_tag | output | PN_W+11 | Packed tag word of the match |
| lk_mask | output | PN_W | Page mask of the match |
| lk_even | output | PFN_W+6 | Packed even half of the match |
| lk_odd | output | PFN_W+6 | Packed odd half of the match |
| pr_pn | input | PN_W | Probe page number |
| pr_asid | input | 8 | Probe identifier |
| pr_miss | output | 1 | Probe found nothing |
| pr_idx | output | IDX_W | Probe matching slot |
| nxt_idx | output | IDX_W | Next-slot pointer |

## Verification
The hardest state to reach from the ports is one where several live entries match the same search at once. This can happen through different masks, or through a global entry that overlaps a private one. It is also hard to reach one where a matching tag sits in a slot whose two valid bits are both clear.

A directed sequence builds these overlaps on purpose. It then adds an out-of-range write of a matching tag and checks that the reported slot does not move. A long pseudo-random phase follows. It draws page numbers, masks and identifiers from small pools, so overlaps and invalid entries keep recurring. A behavioural model in the bench is compared with both search ports and the pointer on every cycle.

// File: rtl/assoc_xlate_array.sv
module assoc_xlate_array #(
  parameter int ENTRIES = 16,
  parameter int PN_W    = 19,
  parameter int PFN_W   = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     wr_en,
  input  logic [$clog2(ENTRIES):0] wr_idx,
  input  logic [PN_W-1:0]          wr_pn,
  input  logic [PN_W-1:0]          wr_mask,
  input  logic [7:0]               wr_asid,
  input  logic [PFN_W+5:0]         wr_even,
  input  logic [PFN_W+5:0]         wr_odd,
  input  logic [PN_W-1:0]          lk_pn,
  input  logic [7:0]               lk_asid,
  output logic                     lk_hit,
  output logic [$clog2(ENTRIES)-1:0] lk_idx,
  output logic [PN_W+10:0]         lk_tag,
  output logic [PN_W-1:0]          lk_mask,
  output logic [PFN_W+5:0]         lk_even,
  output logic [PFN_W+5:0]         lk_odd,
  input  logic [PN_W-1:0]          pr_pn,
  input  logic [7:0]               pr_asid,
  output logic                     pr_miss,
  output logic [$clog2(ENTRIES)-1:0] pr_idx,
  output logic [$clog2(ENTRIES)-1:0] nxt_idx
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int WIX_W  = IDX_W + 1;
  localparam int HALF_W = PFN_W + 6;

  logic [ENTRIES-1:0][PN_W-1:0]     pn_q, mask_q;
  logic [ENTRIES-1:0][7:0]          asid_q;
  logic [ENTRIES-1:0]               g_q;
  logic [ENTRIES-1:0][HALF_W-2:0]   ev_q, od_q;
  logic [IDX_W-1:0]                 nxt_q;
  logic [ENTRIES-1:0]               lk_vec, pr_vec;

  wire wr_ok = wr_en && (wr_idx < WIX_W'(ENTRIES));

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      pn_q   <= '0;
      mask_q <= '0;
      asid_q <= '0;
      g_q    <= '0;
      ev_q   <= '0;
      od_q   <= '0;
      nxt_q  <= '0;
    end else if (wr_ok) begin
      pn_q[wr_idx[IDX_W-1:0]]   <= wr_pn;
      mask_q[wr_idx[IDX_W-1:0]] <= wr_mask;
      asid_q[wr_idx[IDX_W-1:0]] <= wr_asid;
      g_q[wr_idx[IDX_W-1:0]]    <= wr_even[0] & wr_odd[0];
      ev_q[wr_idx[IDX_W-1:0]]   <= wr_even[HALF_W-1:1];
      od_q[wr_idx[IDX_W-1:0]]   <= wr_odd[HALF_W-1:1];
      nxt_q <= (wr_idx[IDX_W-1:0] == IDX_W'(ENTRIES-1)) ? '0 : wr_idx[IDX_W-1:0] + 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      lk_vec[i] = (ev_q[i][0] | od_q[i][0]) &&
                  (((lk_pn ^ pn_q[i]) & ~mask_q[i]) == '0) &&
                  (g_q[i] || asid_q[i] == lk_asid);
      pr_vec[i] = (ev_q[i][0] | od_q[i][0]) &&
                  (((pr_pn ^ pn_q[i]) & ~mask_q[i]) == '0) &&
                  (g_q[i] || asid_q[i] == pr_asid);
    end
  end

  always_comb begin
    lk_idx = '0;
    pr_idx = '0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (lk_vec[i]) lk_idx = IDX_W'(i);
      if (pr_vec[i]) pr_idx = IDX_W'(i);
    end
  end

  assign lk_hit  = |lk_vec;
  assign pr_miss = ~|pr_vec;
  assign nxt_idx = nxt_q;
  assign lk_tag  = lk_hit ? {pn_q[lk_idx], 3'b000, asid_q[lk_idx]} : '0;
  assign lk_mask = lk_hit ? mask_q[lk_idx] : '0;
  assign lk_even = lk_hit ? {ev_q[lk_idx], g_q[lk_idx]} : '0;
  assign lk_odd  = lk_hit ? {od_q[lk_idx], g_q[lk_idx]} : '0;

  // R3
  valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_even[1] | lk_odd[1]));

  // R6
  oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx >= WIX_W'(ENTRIES) && !flush) |=>
      ($stable(pn_q) && $stable(mask_q) && $stable(asid_q) && $stable(g_q) &&
       $stable(ev_q) && $stable(od_q) && $stable(nxt_q)));

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!lk_hit && pr_miss && nxt_idx == '0));

  // R9
  write_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !flush) |=> (pn_q[$past(wr_idx[IDX_W-1:0])] == $past(wr_pn) &&
                           asid_q[$past(wr_idx[IDX_W-1:0])] == $past(wr_asid)));

  // R5
  probe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pr_miss |-> (pr_idx == '0));
endmodule

// File: tb/test_assoc_xlate_array.sv
module test_assoc_xlate_array;
  localparam int N = 16, PN_W = 19, PFN_W = 20, IDX_W = 4, HW = PFN_W + 6;

  logic clk = 0, rst_n = 0, flush = 0, wr_en = 0;
  logic [IDX_W:0] wr_idx = '0;
  logic [PN_W-1:0] wr_pn = '0, wr_mask = '0, lk_pn = '0, pr_pn = '0;
  logic [7:0] wr_asid = '0, lk_asid = '0, pr_asid = '0;
  logic [HW-1:0] wr_even = '0, wr_odd = '0;
  logic lk_hit, pr_miss;
  logic [IDX_W-1:0] lk_idx, pr_idx, nxt_idx;
  logic [PN_W+10:0] lk_tag;
  logic [PN_W-1:0] lk_mask;
  logic [HW-1:0] lk_even, lk_odd;

  assoc_xlate_array #(.ENTRIES(N), .PN_W(PN_W), .PFN_W(PFN_W)) i_assoc_xlate_array (
    .clk, .rst_n, .flush, .wr_en, .wr_idx, .wr_pn, .wr_mask, .wr_asid, .wr_even, .wr_odd,
    .lk_pn, .lk_asid, .lk_hit, .lk_idx, .lk_tag, .lk_mask, .lk_even, .lk_odd,
    .pr_pn, .pr_asid, .pr_miss, .pr_idx, .nxt_idx);

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [PN_W-1:0] m_pn[N], m_mask[N];
  logic [7:0] m_asid[N];
  logic m_g[N];
  logic [HW-1:0] m_ev[N], m_od[N];
  int m_ptr;

  function automatic int model_find(logic [PN_W-1:0] pn, logic [7:0] asid);
    for (int i = 0; i < N; i++)
      if ((m_ev[i][1] | m_od[i][1]) && (((pn ^ m_pn[i]) & ~m_mask[i]) == '0) &&
          (m_g[i] || m_asid[i] == asid))
        return i;
    return -1;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin
      m_pn[i] = '0; m_mask[i] = '0; m_asid[i] = '0; m_g[i] = 0; m_ev[i] = '0; m_od[i] = '0;
    end
    m_ptr = 0;
  endtask

  task automatic compare(string tag);
    int li, pi;
    logic [PN_W+10:0] e_tag;
    logic [PN_W-1:0] e_mask;
    logic [HW-1:0] e_ev, e_od;
    logic e_hit;
    logic [IDX_W-1:0] e_idx, e_pidx;
    li = model_find(lk_pn, lk_asid);
    pi = model_find(pr_pn, pr_asid);
    e_hit = (li >= 0);
    e_idx = e_hit ? IDX_W'(li) : '0;
    e_tag = e_hit ? {m_pn[li], 3'b000, m_asid[li]} : '0;
    e_mask = e_hit ? m_mask[li] : '0;
    e_ev = e_hit ? {m_ev[li][HW-1:1], m_g[li]} : '0;
    e_od = e_hit ? {m_od[li][HW-1:1], m_g[li]} : '0;
    e_pidx = (pi >= 0) ? IDX_W'(pi) : '0;
    tests++;
    if (lk_hit !== e_hit || lk_idx !== e_idx || lk_tag !== e_tag || lk_mask !== e_mask ||
        lk_even !== e_ev || lk_odd !== e_od || pr_miss !== (pi < 0) || pr_idx !== e_pidx ||
        nxt_idx !== IDX_W'(m_ptr)) begin
      fails++;
      $display("FAIL %s: got hit=%0b idx=%0d tag=%h mask=%h ev=%h od=%h pmiss=%0b pidx=%0d nxt=%0d exp hit=%0b idx=%0d tag=%h mask=%h ev=%h od=%h pmiss=%0b pidx=%0d nxt=%0d",
        tag, lk_hit, lk_idx, lk_tag, lk_mask, lk_even, lk_odd, pr_miss, pr_idx, nxt_idx,
        e_hit, e_idx, e_tag, e_mask, e_ev, e_od, (pi < 0), e_pidx, m_ptr);
    end
  endtask

  task automatic step(string tag);
    #5 compare(tag);
    @(posedge clk);
    if (!rst_n || flush) model_clear();
    else if (wr_en && wr_idx < N) begin
      m_pn[wr_idx] = wr_pn; m_mask[wr_idx] = wr_mask; m_asid[wr_idx] = wr_asid;
      m_g[wr_idx] = wr_even[0] & wr_odd[0];
      m_ev[wr_idx] = wr_even & ~HW'(1); m_od[wr_idx] = wr_odd & ~HW'(1);
      m_ptr = (int'(wr_idx) + 1) % N;
    end
    @(negedge clk);
    wr_en = 0; flush = 0;
  endtask

  function automatic logic [HW-1:0] half(int pfn, int attr, bit d, bit v, bit g);
    return {PFN_W'(pfn), 3'(attr), d, v, g};
  endfunction

  task automatic wr(int idx, int pn, int mask, int asid, logic [HW-1:0] ev, logic [HW-1:0] od);
    wr_en = 1; wr_idx = (IDX_W+1)'(idx); wr_pn = PN_W'(pn); wr_mask = PN_W'(mask);
    wr_asid = 8'(asid); wr_even = ev; wr_odd = od;
  endtask

  task automatic look(int pn, int asid);
    lk_pn = PN_W'(pn); lk_asid = 8'(asid); pr_pn = PN_W'(pn); pr_asid = 8'(asid);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    model_clear();
    @(negedge clk); @(negedge clk);
    step("R10 reset");
    rst_n = 1;
    look(19'h100, 5); step("R10 empty after reset");
    wr(2, 19'h100, 0, 5, half(19'h2a, 3, 1, 1, 0), half(19'h2b, 2, 0, 0, 0));
    step("R9 write");
    step("R9 visible next cycle, R8 packing");
    look(19'h100, 6); step("R2 identifier mismatch");
    wr(3, 19'h104, 7, 9, half(19'h30, 5, 0, 0, 1), half(19'h31, 1, 1, 1, 1));
    look(19'h101, 9); step("R1 write masked");
    step("R1 masked match global");
    look(19'h101, 44); step("R2 global ignores identifier");
    look(19'h108, 9); step("R1 unmasked bit differs");
    look(19'h100, 5); step("R4 lowest index wins");
    wr(1, 19'h100, 0, 5, half(19'h11, 0, 1, 0, 1), half(19'h12, 0, 1, 0, 1));
    step("R3 write invalid entry");
    step("R3 invalid entry skipped");
    wr(16, 19'h100, 0, 5, half(19'h7, 0, 1, 1, 1), half(19'h8, 0, 1, 1, 1));
    step("R6 out-of-range write");
    step("R6 array and pointer unchanged");
    wr(31, 19'h100, 0, 5, half(19'h7, 0, 1, 1, 1), half(19'h8, 0, 1, 1, 1));
    step("R6 top index write");
    look(19'h555, 1); step("R5 probe not found");
    wr(15, 19'h555, 0, 1, half(1, 1, 1, 1, 0), half(2, 1, 1, 0, 0));
    step("R9 last slot");
    step("R9 pointer wraps to zero");
    flush = 1; wr(4, 19'h100, 0, 5, half(1, 1, 1, 1, 1), half(1, 1, 1, 1, 1));
    step("R7 flush with write");
    look(19'h100, 5); step("R7 all cleared");
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 2) flush = 1;
      if (r >= 2 && r < 40) begin
        logic [HW-1:0] e, o;
        e = half($urandom_range(0, 1023), $urandom_range(0, 7), 1'($urandom), 1'($urandom),
                 1'($urandom_range(0, 3) == 0));
        o = half($urandom_range(0, 1023), $urandom_range(0, 7), 1'($urandom), 1'($urandom),
                 1'($urandom_range(0, 3) != 0));
        wr($urandom_range(0, 19), 19'h200 + $urandom_range(0, 15),
           ($urandom_range(0, 2) == 0) ? 3 : (($urandom_range(0, 1) == 0) ? 0 : 15),
           $urandom_range(1, 3), e, o);
      end
      lk_pn = PN_W'(19'h200 + $urandom_range(0, 15)); lk_asid = 8'($urandom_range(1, 3));
      pr_pn = PN_W'(19'h200 + $urandom_range(0, 15)); pr_asid = 8'($urandom_range(1, 3));
      step("R5 random traffic");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule